// File: doc/BRIEF.md
# Frame-Synchronised Serial Slave with Output Release Timer

This block is the slave end of a synchronous serial link that uses frame-sync framing. An external master supplies a serial clock, a data line toward the slave and a one-bit-period sync pulse. The slave returns data on its own output line, and that line has a separate output enable so that several slaves can share it. All three link inputs are resynchronised into the system clock domain. Edges of the serial clock are then found in that domain, so the whole block runs on a single system clock.

Timing on the link is fixed. The master changes data on the rising serial-clock edge, and the slave samples on the falling edge. Every frame is eight bits long and is sent most significant bit first. A sync pulse seen on the falling edge just before the first bit opens a frame. The same pulse seen on the falling edge of the last bit chains the next frame with no gap. When a frame ends without a chained one, a counter works out when to release the output line. The delay is taken from a three-bit baud field.

A small register port gives access from the system side. It offers a data register (a write fills the transmit buffer, a read drains the receive buffer), a status register with sticky error bits and a configuration register.

Top module: `tfs_slave`

## Requirements
- R1: After reset the output enable is low, the configuration register reads 0x10 and the status register reads 0x02 (transmit buffer empty, no other flag set).
- R2: The eight bits sampled on the falling edges after a sync are assembled MSB first. Once the eighth bit is in, the byte goes to the receive buffer and status bit 0 (ready) is set. A read of address 0 returns the byte and clears ready.
- R3: A write to address 0 fills the transmit buffer and clears status bit 1 (empty). At frame start the buffer moves to the shifter and bit 1 is set again. If the buffer is empty, 0x00 is sent. Bits leave MSB first, one per rising edge, with the output enabled.
- R4: A sync sampled together with the last bit of a frame starts the next frame right away. The output stays enabled and the next transmit byte follows without a gap.
- R5: After the last bit of a frame with no chained frame, the output enable falls exactly 2^BR + 5 system clocks after the internal falling-edge detection. BR is configuration bits 2:0. Seen from the pins, this is the (2^BR + 8)-th rising system-clock edge after the serial clock falls.
- R6: A byte that completes while ready is still set raises status bit 2 (overrun), and the buffer keeps its older byte. Overrun stays set until a 1 is written to bit 2 of address 1.
- R7: With configuration bit 3 (transmit only) set, received bytes are discarded. Ready and overrun are never set, and transmission continues as normal.
- R8: With configuration bit 4 (frame-sync format) clear, the link is ignored. The output enable stays low and the transmit buffer is not consumed.
- R9: Configuration bits 5 and 6 (clock polarity and phase) read back as written but do not change the sampling edge, the driving edge or the data.
- R10: A sync sampled in the middle of a frame sets status bit 3 (frame error) and starts a new frame from that point. The bit stays set until a 1 is written to bit 3 of address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| fsync_i | input | 1 | Frame-sync pulse from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for miso_o (low means high impedance) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on the data register) |
| bus_addr | input | 2 | Register address: 0 data, 1 status, 2 configuration |
| bus_wdata | input | DW | Register write data |
| bus_rdata | output | DW | Register read data, combinational from the address |

## Verification
The bench builds the block with its default parameters: eight-bit frames and two synchroniser stages. The serial clock runs at sixteen system clocks per bit, which leaves enough room to see single-cycle edge detection and buffering. With the baud field programmed at run time, the bench measures the release delay exactly for BR = 0 and BR = 3, and it covers the point where a chained frame cancels the release. Through the same configuration register the bench reaches transmit-only mode, the non-frame-sync format and the ignored polarity and phase bits.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
  localparam int BR_W = 3;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CFG  = 2'd2;

  localparam int ST_RDY  = 0;
  localparam int ST_TXE  = 1;
  localparam int ST_OVR  = 2;
  localparam int ST_FERR = 3;
  localparam int ST_W    = 4;

  typedef struct packed {
    logic            pha;
    logic            pol;
    logic            ti;
    logic            txo;
    logic [BR_W-1:0] br;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/tfs_sync.sv
module tfs_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= '0;
        else        pipe[g] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= '0;
        else        pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/tfs_frame.sv
module tfs_frame #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          rise,
  input  logic          fall,
  input  logic          mosi,
  input  logic          fs,
  input  logic [DW-1:0] tx_byte,
  input  logic          tx_full,
  output logic [DW-1:0] rx_word,
  output logic          rx_done,
  output logic          start,
  output logic          ferr_set,
  output logic          drive,
  output logic          miso
);
  localparam int IW = (DW > 1) ? $clog2(DW) : 1;
  localparam int OW = $clog2(DW + 1);

  logic          active, active_n;
  logic [IW-1:0] in_cnt, in_cnt_n;
  logic [OW-1:0] out_cnt, out_cnt_n;
  logic [DW-1:0] rx_sh, rx_sh_n;
  logic [DW-1:0] tx_sh, tx_sh_n;
  logic          miso_q, miso_n;
  logic          last, sample;

  assign last     = (in_cnt == IW'(DW - 1));
  assign sample   = en && fall && active;
  assign start    = en && fall && fs;
  assign ferr_set = start && active && !last;
  assign rx_done  = sample && last;
  assign drive    = en && rise && active && (out_cnt < OW'(DW));
  assign rx_word  = {rx_sh[DW-2:0], mosi};
  assign miso     = miso_q;

  always_comb begin
    active_n  = active;
    in_cnt_n  = in_cnt;
    out_cnt_n = out_cnt;
    rx_sh_n   = rx_sh;
    tx_sh_n   = tx_sh;
    miso_n    = miso_q;
    if (sample) begin
      rx_sh_n  = rx_word;
      in_cnt_n = in_cnt + 1'b1;
      if (last) active_n = 1'b0;
    end
    if (start) begin
      active_n  = 1'b1;
      in_cnt_n  = '0;
      out_cnt_n = '0;
      tx_sh_n   = tx_full ? tx_byte : '0;
    end
    if (drive) begin
      miso_n    = tx_sh[DW-1];
      tx_sh_n   = {tx_sh[DW-2:0], 1'b0};
      out_cnt_n = out_cnt + 1'b1;
    end
    if (!en) active_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      in_cnt  <= '0;
      out_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      miso_q  <= 1'b0;
    end else begin
      active  <= active_n;
      in_cnt  <= in_cnt_n;
      out_cnt <= out_cnt_n;
      rx_sh   <= rx_sh_n;
      tx_sh   <= tx_sh_n;
      miso_q  <= miso_n;
    end
  end
endmodule

// File: rtl/tfs_release.sv
module tfs_release
  import tfs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [BR_W-1:0] br,
  input  logic            drive,
  input  logic            arm,
  input  logic            cancel,
  output logic            oe
);
  localparam int CW = (1 << BR_W) + 1;

  logic          oe_q, oe_n;
  logic          busy, busy_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [CW-1:0] load;

  assign load = (CW'(1) << br) + CW'(5);
  assign oe   = oe_q;

  always_comb begin
    oe_n   = oe_q;
    busy_n = busy;
    cnt_n  = cnt;
    if (cancel) busy_n = 1'b0;
    if (drive)  oe_n   = 1'b1;
    if (arm) begin
      busy_n = 1'b1;
      cnt_n  = load;
    end else if (busy) begin
      if (cnt == CW'(1)) begin
        oe_n   = 1'b0;
        busy_n = 1'b0;
      end else begin
        cnt_n = cnt - 1'b1;
      end
    end
    if (!en) begin
      oe_n   = 1'b0;
      busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q <= 1'b0;
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      oe_q <= oe_n;
      busy <= busy_n;
      if (arm || busy) cnt <= cnt_n;
    end
  end
endmodule

// File: rtl/tfs_regs.sv
module tfs_regs
  import tfs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_word,
  input  logic          tx_take,
  input  logic          ferr_set,
  output logic [DW-1:0] tx_byte,
  output logic          tx_full,
  output cfg_t          cfg,
  output logic [ST_W-1:0] stat
);
  logic [DW-1:0] rx_buf, rx_buf_n;
  logic [DW-1:0] tx_buf, tx_buf_n;
  logic          rdy, rdy_n, ovr, ovr_n, ferr, ferr_n, txe, txe_n;
  cfg_t          cfg_q, cfg_n;
  logic          rd_data, wr_data, wr_stat, wr_cfg;

  assign rd_data = bus_rd && (bus_addr == A_DATA);
  assign wr_data = bus_wr && (bus_addr == A_DATA);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign wr_cfg  = bus_wr && (bus_addr == A_CFG);

  assign stat    = {ferr, ovr, txe, rdy};
  assign cfg     = cfg_q;
  assign tx_byte = tx_buf;
  assign tx_full = !txe;

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = rx_buf;
      A_STAT:  bus_rdata = DW'(stat);
      A_CFG:   bus_rdata = DW'(cfg_q);
      default: bus_rdata = '0;
    endcase
  end

  always_comb begin
    rx_buf_n = rx_buf;
    tx_buf_n = tx_buf;
    rdy_n    = rdy;
    ovr_n    = ovr;
    ferr_n   = ferr;
    txe_n    = txe;
    cfg_n    = cfg_q;
    if (rd_data) rdy_n = 1'b0;
    if (wr_stat && bus_wdata[ST_OVR])  ovr_n  = 1'b0;
    if (wr_stat && bus_wdata[ST_FERR]) ferr_n = 1'b0;
    if (rx_done && !cfg_q.txo) begin
      if (rdy && !rd_data) begin
        ovr_n = 1'b1;
      end else begin
        rx_buf_n = rx_word;
        rdy_n    = 1'b1;
      end
    end
    if (ferr_set) ferr_n = 1'b1;
    if (tx_take)  txe_n  = 1'b1;
    if (wr_data) begin
      tx_buf_n = bus_wdata;
      txe_n    = 1'b0;
    end
    if (wr_cfg) cfg_n = cfg_t'(bus_wdata[CFG_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf <= '0;
      tx_buf <= '0;
      rdy    <= 1'b0;
      ovr    <= 1'b0;
      ferr   <= 1'b0;
      txe    <= 1'b1;
      cfg_q  <= '{pha: 1'b0, pol: 1'b0, ti: 1'b1, txo: 1'b0, br: '0};
    end else begin
      if (rx_done || rd_data) rx_buf <= rx_buf_n;
      if (wr_data)            tx_buf <= tx_buf_n;
      rdy   <= rdy_n;
      ovr   <= ovr_n;
      ferr  <= ferr_n;
      txe   <= txe_n;
      if (wr_cfg) cfg_q <= cfg_n;
    end
  end
endmodule

// File: rtl/tfs_slave.sv
module tfs_slave
  import tfs_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_i,
  input  logic          mosi_i,
  input  logic          fsync_i,
  output logic          miso_o,
  output logic          miso_oe_o,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata
);
  logic [2:0]      sync_q;
  logic            sck_s, mosi_s, fs_s, sck_d;
  logic            rise_w, fall_w;
  logic [DW-1:0]   rx_word_w, tx_byte_w;
  logic            rx_done_w, start_w, ferr_w, drive_w, tx_full_w, arm_w;
  cfg_t            cfg_w;
  logic [ST_W-1:0] stat_w;

  tfs_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sck_i, mosi_i, fsync_i}),
    .q(sync_q)
  );

  assign {sck_s, mosi_s, fs_s} = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end

  assign rise_w = sck_s && !sck_d;
  assign fall_w = !sck_s && sck_d;
  assign arm_w  = rx_done_w && !start_w;

  tfs_frame #(.DW(DW)) u_frame (
    .clk(clk), .rst_n(rst_n), .en(cfg_w.ti),
    .rise(rise_w), .fall(fall_w), .mosi(mosi_s), .fs(fs_s),
    .tx_byte(tx_byte_w), .tx_full(tx_full_w),
    .rx_word(rx_word_w), .rx_done(rx_done_w), .start(start_w),
    .ferr_set(ferr_w), .drive(drive_w), .miso(miso_o)
  );

  tfs_release u_rel (
    .clk(clk), .rst_n(rst_n), .en(cfg_w.ti), .br(cfg_w.br),
    .drive(drive_w), .arm(arm_w), .cancel(start_w), .oe(miso_oe_o)
  );

  tfs_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_done(rx_done_w), .rx_word(rx_word_w), .tx_take(start_w),
    .ferr_set(ferr_w), .tx_byte(tx_byte_w), .tx_full(tx_full_w),
    .cfg(cfg_w), .stat(stat_w)
  );
endmodule

// File: rtl/tfs_slave_chk.sv
module tfs_slave_chk
  import tfs_pkg::*;
#(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [1:0]      bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic            miso_oe_o,
  input logic [ST_W-1:0] stat,
  input logic            cfg_ti,
  input logic            cfg_txo,
  input logic            rx_done,
  input logic            arm,
  input logic            ferr_set
);
  p_rdy_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_DATA && !rx_done) |=> !stat[ST_RDY]);

  p_oe_hold_on_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && miso_oe_o && cfg_ti) |=> miso_oe_o);

  p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[ST_OVR] && !(bus_wr && bus_addr == A_STAT && bus_wdata[ST_OVR])) |=> stat[ST_OVR]);

  p_txo_no_ovr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_txo && !stat[ST_OVR]) |=> !stat[ST_OVR]);

  p_fmt_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ti && !miso_oe_o) |=> !miso_oe_o);

  p_ferr_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_set |=> stat[ST_FERR]);
endmodule

bind tfs_slave tfs_slave_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .miso_oe_o(miso_oe_o),
  .stat(stat_w), .cfg_ti(cfg_w.ti), .cfg_txo(cfg_w.txo),
  .rx_done(rx_done_w), .arm(arm_w), .ferr_set(ferr_w)
);

// File: tb/sim_tfs_slave.sv
module sim_tfs_slave;
  localparam int DW = 8;
  localparam int H  = 8;

  logic clk, rst_n, sck_i, mosi_i, fsync_i, miso_o, miso_oe_o;
  logic bus_wr, bus_rd;
  logic [1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  int n_chk = 0, n_err = 0, oe_cnt = 0;
  bit finished = 0;
  logic [7:0] tx_q [$];
  string mon_tag = "R3";

  tfs_slave u0 (
    .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .mosi_i(mosi_i), .fsync_i(fsync_i),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) if (miso_oe_o === 1'b1) oe_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // monitor: master-side capture on falling serial-clock edges
  int mcnt = -1;
  logic [7:0] mbyte;
  logic oe_all;
  always @(negedge sck_i) begin
    if (mcnt >= 0) begin
      mbyte  = {mbyte[6:0], miso_o};
      oe_all = oe_all & miso_oe_o;
      mcnt++;
      if (mcnt == 8) begin
        if (tx_q.size() > 0) begin
          logic [7:0] e;
          e = tx_q.pop_front();
          chk({mon_tag, " miso byte with enable"}, {23'd0, oe_all, mbyte}, {23'd0, 1'b1, e});
        end
        mcnt = -1;
      end
    end
    if (fsync_i === 1'b1) begin
      mcnt   = 0;
      oe_all = 1'b1;
    end
  end

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    reg_rd(a, v);
    chk(req, {24'd0, v}, {24'd0, exp});
  endtask

  task automatic sck_bit(input logic m, input logic f);
    @(negedge clk);
    sck_i = 1'b1; mosi_i = m; fsync_i = f;
    repeat (H) @(negedge clk);
    sck_i = 1'b0;
    repeat (H - 1) @(negedge clk);
  endtask

  // driver: n chained frames; expected transmit bytes are queued by caller
  task automatic frames(input logic [7:0] b0, input logic [7:0] b1, input int n);
    sck_bit(1'b0, 1'b1);
    for (int k = 0; k < n; k++) begin
      logic [7:0] b;
      b = (k == 0) ? b0 : b1;
      for (int i = 7; i >= 0; i--) sck_bit(b[i], (i == 0) && (k < n - 1));
    end
    @(negedge clk); fsync_i = 1'b0;
  endtask

  task automatic release_test(input int br, input logic [7:0] b);
    int n;
    n = (1 << br) + 5;
    reg_wr(2'd2, 8'h10 | 8'(br));
    tx_q.push_back(8'h00);
    sck_bit(1'b0, 1'b1);
    for (int i = 7; i >= 1; i--) sck_bit(b[i], 1'b0);
    @(negedge clk);
    sck_i = 1'b1; mosi_i = b[0]; fsync_i = 1'b0;
    repeat (H) @(negedge clk);
    sck_i = 1'b0;
    repeat (n + 2) @(negedge clk);
    chk("R5 enable still high before release", {31'd0, miso_oe_o}, 32'd1);
    @(negedge clk);
    chk("R5 enable low at release", {31'd0, miso_oe_o}, 32'd0);
    rd_chk(2'd0, b, "R2 byte of release frame");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  initial begin
    int o0;
    rst_n = 1'b0; sck_i = 1'b0; mosi_i = 1'b0; fsync_i = 1'b0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    chk("R1 enable low in reset", {31'd0, miso_oe_o}, 32'd0);
    rst_n = 1'b1;
    rd_chk(2'd1, 8'h02, "R1 status after reset");
    rd_chk(2'd2, 8'h10, "R1 config after reset");
    chk("R1 enable low after reset", {31'd0, miso_oe_o}, 32'd0);

    // basic exchange
    reg_wr(2'd0, 8'hA5);
    rd_chk(2'd1, 8'h00, "R3 empty cleared by write");
    tx_q.push_back(8'hA5);
    frames(8'h3C, 8'h00, 1);
    rd_chk(2'd1, 8'h03, "R2 R3 ready and empty after frame");
    rd_chk(2'd0, 8'h3C, "R2 received byte");
    rd_chk(2'd1, 8'h02, "R2 ready cleared by read");

    // empty transmit buffer sends zero
    tx_q.push_back(8'h00);
    frames(8'h81, 8'h00, 1);
    rd_chk(2'd0, 8'h81, "R2 received byte second pattern");

    // chained frames, second one overruns
    mon_tag = "R4";
    reg_wr(2'd0, 8'h5A);
    tx_q.push_back(8'h5A);
    tx_q.push_back(8'h00);
    frames(8'h11, 8'h22, 2);
    rd_chk(2'd1, 8'h07, "R6 overrun with ready");
    rd_chk(2'd0, 8'h11, "R6 older byte kept");
    rd_chk(2'd1, 8'h06, "R6 overrun sticky after read");
    reg_wr(2'd1, 8'h04);
    rd_chk(2'd1, 8'h02, "R6 overrun cleared");

    // release timing
    mon_tag = "R5";
    release_test(0, 8'hC3);
    release_test(3, 8'h3A);

    // transmit only
    mon_tag = "R7";
    reg_wr(2'd2, 8'h18);
    reg_wr(2'd0, 8'h96);
    tx_q.push_back(8'h96);
    tx_q.push_back(8'h00);
    frames(8'h77, 8'h00, 1);
    frames(8'h78, 8'h00, 1);
    rd_chk(2'd1, 8'h02, "R7 no ready no overrun");

    // polarity and phase bits ignored
    mon_tag = "R9";
    reg_wr(2'd2, 8'h70);
    rd_chk(2'd2, 8'h70, "R9 config readback");
    reg_wr(2'd0, 8'hE1);
    tx_q.push_back(8'hE1);
    frames(8'h4B, 8'h00, 1);
    rd_chk(2'd0, 8'h4B, "R9 received byte unchanged");

    // non frame-sync format ignored
    reg_wr(2'd2, 8'h00);
    reg_wr(2'd0, 8'h99);
    o0 = oe_cnt;
    frames(8'h12, 8'h00, 1);
    chk("R8 enable never high", oe_cnt - o0, 32'd0);
    rd_chk(2'd1, 8'h00, "R8 nothing received, buffer kept");

    // frame error
    mon_tag = "R10";
    reg_wr(2'd2, 8'h10);
    tx_q.push_back(8'h00);
    sck_bit(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) sck_bit(1'b1, 1'b0);
    sck_bit(1'b1, 1'b1);
    for (int i = 7; i >= 0; i--) sck_bit(8'h6D >> i, 1'b0);
    rd_chk(2'd1, 8'h0B, "R10 frame error flag");
    rd_chk(2'd0, 8'h6D, "R10 restarted frame byte");
    rd_chk(2'd1, 8'h0A, "R10 error sticky");
    reg_wr(2'd1, 8'h08);
    rd_chk(2'd1, 8'h02, "R10 error cleared");

    chk("R3 all expected bytes seen", tx_q.size(), 32'd0);
    repeat (10) @(negedge clk);
    finish_up();
  end
endmodule